// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Filter

This block sits downstream of a coarse, bank-wide "something changed" interrupt and resolves which individual pins actually produced a qualifying edge. Each pin carries its own enable bit and its own choice of rising, falling or both edges. On every evaluation strobe the block compares the live pin sample with a stored snapshot from the previous evaluation. It reports rising, falling and combined event vectors, and then replaces the snapshot with the live sample.

Pins that fired are handed out one at a time as pin indices on a valid/ready stream, lowest index first. A single-cycle done pulse follows the last index. Pin configuration arrives through a small command port that sets the edge type, arms a pin or disarms it. Arming a pin that was idle refreshes the snapshot of its whole bank, so that stale history cannot raise a spurious event. The pin space is divided into banks of 32; with the default 64 pins, pins 0 to 31 form bank 0 and pins 32 to 63 form bank 1.

Top module: `pin_edge_filter`

## Requirements
- R1: On an evaluation, a pin sets its rising_vec bit only if its snapshot bit is 0, its live bit is 1, it is armed, and its edge type includes rising.
- R2: On an evaluation, a pin sets its falling_vec bit only if its snapshot bit is 1, its live bit is 0, it is armed, and its edge type includes falling.
- R3: Every evaluation overwrites the whole snapshot with the live sample, whether or not any pin fired.
- R4: Command op 0 sets a pin's edge type from cmd_type, where bit 0 selects rising and bit 1 selects falling. Type 2'b00, and command op 3, are rejected: cmd_err pulses in the cycle after the command and no mask changes.
- R5: Op 1 arms a pin. If the pin was disarmed, the snapshot of that pin's bank (pin index divided by 32) is reloaded from the live sample at the same edge. Op 2 disarms a pin.
- R6: bank_en[b] is high exactly while at least one pin of bank b is armed, so it drops when the last armed pin of that bank is disarmed.
- R7: evt_vec equals rising_vec OR falling_vec, and no pin is reported as both rising and falling.
- R8: Fired pins appear on idx_data in ascending order, one per cycle in which idx_valid and idx_ready are both high. idx_data is held stable while idx_ready is low.
- R9: done is high for one cycle, in the cycle after the handshake of the last fired pin. An evaluation with no events produces no index and no done.
- R10: A strobe that arrives while indices are still being dispatched is held. It is evaluated, against the live sample at that time, in the cycle after dispatch empties.
- R11: After reset all masks, the snapshot, all event vectors, idx_valid, done, cmd_err and bank_en are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_now | input | NPINS | Live pin sample |
| strobe | input | 1 | Evaluation request |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set type, 1 arm, 2 disarm, 3 invalid |
| cmd_pin | input | PW | Pin index addressed by the command |
| cmd_type | input | 2 | Edge type: bit 0 rising, bit 1 falling |
| cmd_err | output | 1 | Rejected-command pulse |
| bank_en | output | NBANK | Per-bank "some pin armed" flag |
| rising_vec | output | NPINS | Rising events of the last evaluation |
| falling_vec | output | NPINS | Falling events of the last evaluation |
| evt_vec | output | NPINS | Combined events of the last evaluation |
| idx_valid | output | 1 | Index stream valid |
| idx_ready | input | 1 | Index stream ready |
| idx_data | output | PW | Index of the next fired pin |
| done | output | 1 | Pulse after the last index has been accepted |

## Verification
The hardest case to reach is a strobe that lands while dispatch is stalled. At that point the pins have moved again, so the held evaluation must use the newer sample and the snapshot left behind by the earlier evaluation. The stimulus creates this case by toggling every pin, to guarantee a non-empty dispatch. It then issues a second strobe with ready held low and a different pattern, and drains both batches under a stuttering ready. Snapshot refresh on arming is reached separately: a whole bank is disarmed, the pins are moved without a strobe, and the bank is re-armed, after which that bank must report nothing.

// File: rtl/pef_pkg.sv
package pef_pkg;

  typedef enum logic [1:0] {
    OP_TYPE   = 2'd0,
    OP_ARM    = 2'd1,
    OP_DISARM = 2'd2,
    OP_BAD    = 2'd3
  } pef_op_e;

endpackage

// File: rtl/pef_cfg.sv
module pef_cfg
  import pef_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int BANK_W = 32,
  localparam int PW    = $clog2(NPINS),
  localparam int NBANK = NPINS / BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [PW-1:0]    cmd_pin,
  input  logic [1:0]       cmd_type,
  output logic [NPINS-1:0] arm_q,
  output logic [NPINS-1:0] rsel_q,
  output logic [NPINS-1:0] fsel_q,
  output logic [NBANK-1:0] refresh,
  output logic [NBANK-1:0] bank_en,
  output logic             cmd_err
);

  localparam int BLG = $clog2(BANK_W);

  logic [NPINS-1:0] arm_d, rsel_d, fsel_d;
  logic             err_d;
  logic             upd;
  pef_op_e          op;

  assign op = pef_op_e'(cmd_op);

  always_comb begin
    arm_d   = arm_q;
    rsel_d  = rsel_q;
    fsel_d  = fsel_q;
    err_d   = 1'b0;
    refresh = '0;
    if (cmd_valid) begin
      case (op)
        OP_TYPE: begin
          if (cmd_type == 2'b00) begin
            err_d = 1'b1;
          end else begin
            rsel_d[cmd_pin] = cmd_type[0];
            fsel_d[cmd_pin] = cmd_type[1];
          end
        end
        OP_ARM: begin
          if (!arm_q[cmd_pin]) begin
            arm_d[cmd_pin] = 1'b1;
            refresh = NBANK'(1) << (cmd_pin >> BLG);
          end
        end
        OP_DISARM: arm_d[cmd_pin] = 1'b0;
        default:   err_d = 1'b1;
      endcase
    end
  end

  assign upd = cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      rsel_q <= '0;
      fsel_q <= '0;
    end else if (upd) begin
      arm_q  <= arm_d;
      rsel_q <= rsel_d;
      fsel_q <= fsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= err_d;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_en[g] = |arm_q[g*BANK_W +: BANK_W];
  end

endmodule

// File: rtl/pef_eval.sv
module pef_eval #(
  parameter int NPINS  = 64,
  parameter int BANK_W = 32,
  localparam int NBANK = NPINS / BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NPINS-1:0] pin_now,
  input  logic [NPINS-1:0] arm_q,
  input  logic [NPINS-1:0] rsel_q,
  input  logic [NPINS-1:0] fsel_q,
  input  logic [NBANK-1:0] refresh,
  output logic [NPINS-1:0] evt_n,
  output logic [NPINS-1:0] rise_q,
  output logic [NPINS-1:0] fall_q,
  output logic [NPINS-1:0] evt_q
);

  logic [NPINS-1:0] prev_q, prev_d;
  logic [NPINS-1:0] rise_n, fall_n;
  logic             prev_en;

  assign rise_n = ~prev_q & pin_now & arm_q & rsel_q;
  assign fall_n = prev_q & ~pin_now & arm_q & fsel_q;
  assign evt_n  = rise_n | fall_n;

  for (genvar g = 0; g < NBANK; g++) begin : g_snap
    assign prev_d[g*BANK_W +: BANK_W] = (go || refresh[g]) ?
        pin_now[g*BANK_W +: BANK_W] : prev_q[g*BANK_W +: BANK_W];
  end

  assign prev_en = go || (|refresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      evt_q  <= '0;
    end else if (go) begin
      rise_q <= rise_n;
      fall_q <= fall_n;
      evt_q  <= evt_n;
    end
  end

endmodule

// File: rtl/pef_dispatch.sv
module pef_dispatch #(
  parameter int NPINS = 64,
  localparam int PW   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NPINS-1:0] evt_n,
  input  logic             idx_ready,
  output logic             idx_valid,
  output logic [PW-1:0]    idx_data,
  output logic             busy,
  output logic             done
);

  logic [NPINS-1:0] remain_q, remain_d, lowbit, rest;
  logic             take, done_d, rem_en;

  assign lowbit    = remain_q & (~remain_q + NPINS'(1));
  assign rest      = remain_q & ~lowbit;
  assign idx_valid = |remain_q;
  assign busy      = idx_valid;
  assign take      = idx_valid && idx_ready;

  always_comb begin
    idx_data = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (remain_q[i]) idx_data = PW'(i);
    end
  end

  always_comb begin
    remain_d = remain_q;
    if (go)        remain_d = evt_n;
    else if (take) remain_d = rest;
    done_d = take && (rest == '0);
  end

  assign rem_en = go || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain_q <= '0;
    else if (rem_en) remain_q <= remain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= done_d;
  end

endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
  parameter int NPINS  = 64,
  parameter int BANK_W = 32,
  localparam int PW    = $clog2(NPINS),
  localparam int NBANK = NPINS / BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_now,
  input  logic             strobe,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [PW-1:0]    cmd_pin,
  input  logic [1:0]       cmd_type,
  output logic             cmd_err,
  output logic [NBANK-1:0] bank_en,
  output logic [NPINS-1:0] rising_vec,
  output logic [NPINS-1:0] falling_vec,
  output logic [NPINS-1:0] evt_vec,
  output logic             idx_valid,
  input  logic             idx_ready,
  output logic [PW-1:0]    idx_data,
  output logic             done
);

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [NPINS-1:0] arm_w, rsel_w, fsel_w, evt_n;
  logic [NBANK-1:0] refresh;
  logic             busy, go, pend_q, pend_d;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign go = (strobe || pend_q) && !busy;

  always_comb begin
    pend_d = pend_q;
    if (go)                   pend_d = 1'b0;
    else if (strobe && busy)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pend_q <= 1'b0;
    else            pend_q <= pend_d;
  end

  pef_cfg #(.NPINS(NPINS), .BANK_W(BANK_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_pin  (cmd_pin),
    .cmd_type (cmd_type),
    .arm_q    (arm_w),
    .rsel_q   (rsel_w),
    .fsel_q   (fsel_w),
    .refresh  (refresh),
    .bank_en  (bank_en),
    .cmd_err  (cmd_err)
  );

  pef_eval #(.NPINS(NPINS), .BANK_W(BANK_W)) u_eval (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .go     (go),
    .pin_now(pin_now),
    .arm_q  (arm_w),
    .rsel_q (rsel_w),
    .fsel_q (fsel_w),
    .refresh(refresh),
    .evt_n  (evt_n),
    .rise_q (rising_vec),
    .fall_q (falling_vec),
    .evt_q  (evt_vec)
  );

  pef_dispatch #(.NPINS(NPINS)) u_disp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .go       (go),
    .evt_n    (evt_n),
    .idx_ready(idx_ready),
    .idx_valid(idx_valid),
    .idx_data (idx_data),
    .busy     (busy),
    .done     (done)
  );

endmodule

// File: rtl/pef_checker.sv
module pef_checker #(
  parameter int NPINS = 64,
  localparam int PW   = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] rising_vec,
  input logic [NPINS-1:0] falling_vec,
  input logic [NPINS-1:0] evt_vec,
  input logic             idx_valid,
  input logic             idx_ready,
  input logic [PW-1:0]    idx_data,
  input logic             done,
  input logic             cmd_err,
  input logic [NPINS-1:0] rsel_w,
  input logic [NPINS-1:0] fsel_w
);

  // R7: a pin never reports both edges in one evaluation
  a_r7_no_both_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (rising_vec & falling_vec) == '0);

  // R8: any offered index is a pin of the latest event vector
  a_r8_idx_in_evt: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> evt_vec[idx_data]);

  // R8: a stalled index is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && !idx_ready |=> idx_valid && $stable(idx_data));

  // R8: indices rise strictly within one batch
  a_r8_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && idx_ready |=> !idx_valid || (idx_data > $past(idx_data)));

  // R9: done comes with an empty dispatcher
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !idx_valid);

  // R4: a rejected command leaves the edge masks untouched
  a_r4_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (rsel_w == $past(rsel_w)) && (fsel_w == $past(fsel_w)));

endmodule

bind pin_edge_filter pef_checker #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .rising_vec (rising_vec),
  .falling_vec(falling_vec),
  .evt_vec    (evt_vec),
  .idx_valid  (idx_valid),
  .idx_ready  (idx_ready),
  .idx_data   (idx_data),
  .done       (done),
  .cmd_err    (cmd_err),
  .rsel_w     (rsel_w),
  .fsel_w     (fsel_w)
);

// File: tb/pin_edge_filter_test.sv
module pin_edge_filter_test;

  logic        clk;
  logic        rst_n;
  logic [63:0] pin_now;
  logic        strobe;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [5:0]  cmd_pin;
  logic [1:0]  cmd_type;
  logic        cmd_err;
  logic [1:0]  bank_en;
  logic [63:0] rising_vec, falling_vec, evt_vec;
  logic        idx_valid, idx_ready, done;
  logic [5:0]  idx_data;

  int total = 0;
  int fails = 0;

  logic [63:0] m_en = '0, m_rs = '0, m_fs = '0, m_prev = '0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  pin_edge_filter uut (
    .clk(clk), .rst_n(rst_n), .pin_now(pin_now), .strobe(strobe),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pin(cmd_pin),
    .cmd_type(cmd_type), .cmd_err(cmd_err), .bank_en(bank_en),
    .rising_vec(rising_vec), .falling_vec(falling_vec), .evt_vec(evt_vec),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic do_cmd(input logic [1:0] op, input int pin, input logic [1:0] ty);
    bit exp_err;
    exp_err = (op == 2'd3) || (op == 2'd0 && ty == 2'b00);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pin = pin[5:0]; cmd_type = ty;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_err == exp_err, "R4 cmd_err", 64'(cmd_err), 64'(exp_err));
    if (!exp_err) begin
      case (op)
        2'd0: begin m_rs[pin] = ty[0]; m_fs[pin] = ty[1]; end
        2'd1: if (!m_en[pin]) begin
                m_en[pin] = 1'b1;
                m_prev[(pin / 32) * 32 +: 32] = pin_now[(pin / 32) * 32 +: 32];
              end
        default: m_en[pin] = 1'b0;
      endcase
    end
  endtask

  function automatic logic [63:0] model_eval(input logic [63:0] p);
    logic [63:0] r, f;
    r = ~m_prev & p & m_en & m_rs;
    f = m_prev & ~p & m_en & m_fs;
    m_prev = p;
    return r | f;
  endfunction

  task automatic check_vecs(input logic [63:0] old_prev, input logic [63:0] p);
    logic [63:0] r, f;
    r = ~old_prev & p & m_en & m_rs;
    f = old_prev & ~p & m_en & m_fs;
    check(rising_vec == r, "R1 rising", rising_vec, r);
    check(falling_vec == f, "R2 falling", falling_vec, f);
    check(evt_vec == (r | f), "R7 combined", evt_vec, r | f);
  endtask

  // called at the negedge where the batch is first visible
  task automatic drain(input logic [63:0] e);
    logic [63:0] left;
    int n, c;
    left = e;
    n = $countones(e);
    c = 0;
    if (n == 0) begin
      check(idx_valid == 1'b0, "R9 no index", 64'(idx_valid), 64'd0);
      return;
    end
    while (left != '0 && c < 400) begin
      int want;
      want = 0;
      for (int i = 63; i >= 0; i--) if (left[i]) want = i;
      idx_ready = (c % 3 != 1);
      check(idx_valid == 1'b1, "R8 valid", 64'(idx_valid), 64'd1);
      check(int'(idx_data) == want, "R8 order", 64'(idx_data), 64'(want));
      if (idx_ready) left[want] = 1'b0;
      c++;
      @(negedge clk);
    end
    idx_ready = 1'b0;
    check(done == 1'b1, "R9 done", 64'(done), 64'd1);
    check(idx_valid == 1'b0, "R9 empty", 64'(idx_valid), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R9 one pulse", 64'(done), 64'd0);
  endtask

  task automatic do_eval(input logic [63:0] p);
    logic [63:0] old, e;
    @(negedge clk);
    pin_now = p; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    old = m_prev;
    e = model_eval(p);
    check_vecs(old, p);
    drain(e);
  endtask

  task automatic do_pending(input logic [63:0] p2);
    logic [63:0] p1, old, e1, e2;
    p1 = ~m_prev;
    @(negedge clk);
    pin_now = p1; strobe = 1'b1;
    @(negedge clk);
    old = m_prev;
    e1 = model_eval(p1);
    check_vecs(old, p1);
    pin_now = p2; strobe = 1'b1; idx_ready = 1'b0;
    @(negedge clk);
    strobe = 1'b0;
    check(evt_vec == e1, "R10 held while busy", evt_vec, e1);
    drain(e1);
    old = m_prev;
    e2 = model_eval(p2);
    check_vecs(old, p2);
    check(evt_vec == e2, "R10 pending evaluated", evt_vec, e2);
    drain(e2);
  endtask

  initial begin
    rst_n = 1'b0; pin_now = '0; strobe = 1'b0; cmd_valid = 1'b0;
    cmd_op = 2'd0; cmd_pin = '0; cmd_type = 2'b00; idx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check(rising_vec == '0, "R11 rising", rising_vec, '0);
    check(falling_vec == '0, "R11 falling", falling_vec, '0);
    check(evt_vec == '0, "R11 evt", evt_vec, '0);
    check(bank_en == 2'b00, "R11 bank_en", 64'(bank_en), 64'd0);
    check(idx_valid == 1'b0 && done == 1'b0, "R11 dispatch", 64'(idx_valid), 64'd0);
    check(cmd_err == 1'b0, "R11 cmd_err", 64'(cmd_err), 64'd0);

    // nothing armed: no events (R1, R2)
    do_eval(next_rand());

    // edge types: pin%3 -> both, rising, falling (R4)
    for (int i = 0; i < 64; i++)
      do_cmd(2'd0, i, (i % 3 == 0) ? 2'b11 : ((i % 3 == 1) ? 2'b01 : 2'b10));
    // arm all pins except every fourth (R5)
    for (int i = 0; i < 64; i++)
      if (i % 4 != 3) do_cmd(2'd1, i, 2'b00);
    check(bank_en == 2'b11, "R6 both banks armed", 64'(bank_en), 64'd3);

    // rejected commands (R4)
    do_cmd(2'd0, 1, 2'b00);
    do_cmd(2'd3, 2, 2'b11);
    do_cmd(2'd0, 4, 2'b00);

    // R3: same sample twice gives nothing second time
    do_eval(64'hFFFF_0000_FFFF_0000);
    do_eval(64'hFFFF_0000_FFFF_0000);
    check(evt_vec == '0, "R3 snapshot updated", evt_vec, '0);

    // sweep of random samples
    for (int k = 0; k < 40; k++) do_eval(next_rand());

    // R5/R6: disarm bank 0, move pins, re-arm bank 0
    for (int i = 0; i < 32; i++) do_cmd(2'd2, i, 2'b00);
    check(bank_en == 2'b10, "R6 bank0 off", 64'(bank_en), 64'd2);
    @(negedge clk);
    pin_now = {pin_now[63:32], ~pin_now[31:0]};
    for (int i = 0; i < 32; i++)
      if (i % 4 != 3) do_cmd(2'd1, i, 2'b00);
    check(bank_en == 2'b11, "R6 bank0 back", 64'(bank_en), 64'd3);
    do_eval(pin_now);
    check(evt_vec[31:0] == '0, "R5 refreshed bank quiet", 64'(evt_vec[31:0]), 64'd0);

    // R10: strobe during dispatch
    do_pending(next_rand());
    do_pending(64'h0123_4567_89AB_CDEF);

    // R6: last armed pin of bank 1 disarmed
    for (int i = 32; i < 64; i++) do_cmd(2'd2, i, 2'b00);
    check(bank_en == 2'b01, "R6 bank1 off", 64'(bank_en), 64'd1);
    do_eval(next_rand());

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule